// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between the command bus of a parallel NOR flash and the engine that actually programs and erases the array. It watches synchronous write strobes carrying an address and a 16-bit data word. It decodes the low data byte as a command and walks the multi-write command sequences. When a sequence is complete and allowed, it raises a single-cycle request with an operation kind, address, data and count. A buffered write stages its data in a small local buffer, and the engine reads that buffer back by index.

The decoder owns one lock bit per block and a status byte. Every modifying request is checked against the target block's lock bit together with the write-protect input. A request that is refused or a sequence that is broken sets a sticky error flag. The decoder then returns to idle without issuing anything. The engine reports progress only through its busy input, which the decoder reflects as the ready flag.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Program setup code 40h or 10h followed by one more write issues kind 1 (program) with that write's address and data. With `byteMode` high, the upper data byte of the program data is forced to zero.
- R2: Code E8h, given at a target address, starts a buffered write. The next write's data is the count N, and the following N+1 writes are stored as address/data pairs at buffer indices 0..N. Code D0h then issues kind 2 with `opAddr` equal to the target address and `opCount` equal to N. A count of `BUF_DEPTH` or more sets the sequence error.
- R3: In a buffered write, D0h must be the write that directly follows the N+1 data writes. Any other value there aborts the sequence, sets the sequence error and issues nothing.
- R4: Block erase (20h) and chip erase (30h) issue kinds 3 and 4 only when the next write is D0h. Any other value sets the sequence error. The block erase address is the address of the D0h write.
- R5: B0h while `engBusy` is high issues kind 5 (suspend) and sets the suspended flag. D0h while suspended issues kind 6 (resume) and clears that flag. Any other command while suspended, except 70h/FFh/50h, sets the sequence error and leaves the block suspended.
- R6: Lock bit 0 means locked, and the block index is the top log2(`NUM_BLOCKS`) address bits. With `wpHigh` low, a program, block erase, buffered write or suspend aimed at a locked block sets the lock error and issues nothing. A chip erase is refused the same way when any block is locked. With `wpHigh` high, all of these proceed.
- R7: 60h then 01h locks the addressed block, and 60h then D0h unlocks all blocks at once. Both take effect only with `wpHigh` high, and set the lock error otherwise. Any other second value sets the sequence error.
- R8: Only data bits 7:0 are decoded as a command, so the upper byte has no effect on decoding.
- R9: Undefined codes, and a lone D0h or 01h in idle, set the sequence error and issue nothing. B0h with the engine idle is ignored.
- R10: `statusReg` bit 7 is the inverse of `engBusy`, bit 6 is suspended, bit 5 is the sequence error and bit 4 is the lock error. Bits 3:0 are zero. Both error bits stay set until a 50h write clears them.
- R11: 70h sets `readStatus` and FFh clears it. After reset, `readStatus` is 0, all blocks are unlocked and `statusReg` is 80h while the engine is idle.
- R12: A write is taken on the rising edge of `wrStrobe`, so a strobe held high counts once. A resulting request pulses `opStart` in the cycle after the clock edge that sampled that rise.
- R13: While `engBusy` is high and nothing is suspended, any command other than B0h, 70h, FFh or 50h sets the sequence error and issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | Command bus write strobe, sampled on clk |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| byteMode | input | 1 | High for 8-bit bus operation |
| wpHigh | input | 1 | Write-protect input level |
| engBusy | input | 1 | Backend engine busy |
| bufRdIdx | input | log2(BUF_DEPTH) | Buffer index read by the engine |
| opStart | output | 1 | One-cycle operation request |
| opKind | output | 3 | 1 program, 2 buffered, 3 block erase, 4 chip erase, 5 suspend, 6 resume |
| opAddr | output | ADDR_W | Operation address |
| opData | output | DATA_W | Program data |
| opCount | output | log2(BUF_DEPTH) | Buffered write count N |
| bufRdAddr | output | ADDR_W | Buffered address at bufRdIdx |
| bufRdData | output | DATA_W | Buffered data at bufRdIdx |
| statusReg | output | 8 | Status byte |
| readStatus | output | 1 | Status read mode selected |

## Verification
Every result of a write appears in the cycle after the clock edge that samples the strobe's rise. This covers the request pulse, its fields, the error and suspended flags, the lock bits and the read mode. The ready flag is the exception and follows `engBusy` within the same cycle. The bench therefore raises the strobe at a falling edge and samples all outputs at the next falling edge, the one that follows the sampling rise. It drops the strobe and leaves one idle cycle before the next write. The buffer readout is combinational in `bufRdIdx` and is checked shortly after the index changes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROG    = 3'd1,
    OP_BUFWR   = 3'd2,
    OP_BLKERS  = 3'd3,
    OP_CHIPERS = 3'd4,
    OP_SUSPEND = 3'd5,
    OP_RESUME  = 3'd6
  } opkind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_BUFCNT, ST_BUFDATA, ST_BUFCONF,
    ST_ERASE, ST_CHIP, ST_LOCK, ST_SUSP
  } dec_state_e;

  localparam logic [7:0] CMD_PROG_A     = 8'h40;
  localparam logic [7:0] CMD_PROG_B     = 8'h10;
  localparam logic [7:0] CMD_BUFWR      = 8'hE8;
  localparam logic [7:0] CMD_BLKERS     = 8'h20;
  localparam logic [7:0] CMD_CHIPERS    = 8'h30;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET   = 8'h01;
  localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;

  typedef struct packed {
    logic    issue;
    opkind_e kind;
    logic    latchTarget;
    logic    bufStart;
    logic    bufPush;
    logic    setLock;
    logic    clrLocks;
    logic    seqErr;
    logic    lockErr;
    logic    clrStatus;
    logic    selStatus;
    logic    selArray;
    logic    suspSet;
    logic    suspClr;
  } ctrl_stb_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wrEvt,
  input  logic [7:0] cmdCode,
  input  logic      engBusy,
  input  logic      wpHigh,
  input  logic      lockOk,
  input  logic      anyLocked,
  input  logic      countOk,
  input  logic      lastData,
  output ctrl_stb_t stb
);

  dec_state_e state, nxt;
  logic modeCmd;

  assign modeCmd = (cmdCode == CMD_RD_STATUS) || (cmdCode == CMD_RD_ARRAY) ||
                   (cmdCode == CMD_CLR_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    stb = '0;
    stb.kind = OP_NONE;
    nxt = state;
    if (wrEvt) begin
      unique case (state)
        ST_IDLE: begin
          if (modeCmd) begin
            stb.selStatus = (cmdCode == CMD_RD_STATUS);
            stb.selArray  = (cmdCode == CMD_RD_ARRAY);
            stb.clrStatus = (cmdCode == CMD_CLR_STATUS);
          end else if (engBusy) begin
            if (cmdCode == CMD_SUSPEND) begin
              if (lockOk) begin
                stb.issue   = 1'b1;
                stb.kind    = OP_SUSPEND;
                stb.suspSet = 1'b1;
                nxt         = ST_SUSP;
              end else begin
                stb.lockErr = 1'b1;
              end
            end else begin
              stb.seqErr = 1'b1;
            end
          end else begin
            case (cmdCode)
              CMD_PROG_A, CMD_PROG_B: nxt = ST_PROG;
              CMD_BUFWR: begin
                if (lockOk) begin
                  stb.latchTarget = 1'b1;
                  nxt = ST_BUFCNT;
                end else begin
                  stb.lockErr = 1'b1;
                end
              end
              CMD_BLKERS:     nxt = ST_ERASE;
              CMD_CHIPERS:    nxt = ST_CHIP;
              CMD_LOCK_SETUP: nxt = ST_LOCK;
              CMD_SUSPEND:    ;
              default:        stb.seqErr = 1'b1;
            endcase
          end
        end
        ST_PROG: begin
          if (lockOk) begin
            stb.issue = 1'b1;
            stb.kind  = OP_PROG;
          end else begin
            stb.lockErr = 1'b1;
          end
          nxt = ST_IDLE;
        end
        ST_BUFCNT: begin
          if (countOk) begin
            stb.bufStart = 1'b1;
            nxt = ST_BUFDATA;
          end else begin
            stb.seqErr = 1'b1;
            nxt = ST_IDLE;
          end
        end
        ST_BUFDATA: begin
          stb.bufPush = 1'b1;
          if (lastData) nxt = ST_BUFCONF;
        end
        ST_BUFCONF: begin
          if (cmdCode == CMD_CONFIRM) begin
            stb.issue = 1'b1;
            stb.kind  = OP_BUFWR;
          end else begin
            stb.seqErr = 1'b1;
          end
          nxt = ST_IDLE;
        end
        ST_ERASE: begin
          if (cmdCode != CMD_CONFIRM) stb.seqErr = 1'b1;
          else if (!lockOk)           stb.lockErr = 1'b1;
          else begin
            stb.issue = 1'b1;
            stb.kind  = OP_BLKERS;
          end
          nxt = ST_IDLE;
        end
        ST_CHIP: begin
          if (cmdCode != CMD_CONFIRM)     stb.seqErr = 1'b1;
          else if (anyLocked && !wpHigh) stb.lockErr = 1'b1;
          else begin
            stb.issue = 1'b1;
            stb.kind  = OP_CHIPERS;
          end
          nxt = ST_IDLE;
        end
        ST_LOCK: begin
          if (cmdCode == CMD_LOCK_SET) begin
            if (wpHigh) stb.setLock = 1'b1;
            else        stb.lockErr = 1'b1;
          end else if (cmdCode == CMD_CONFIRM) begin
            if (wpHigh) stb.clrLocks = 1'b1;
            else        stb.lockErr = 1'b1;
          end else begin
            stb.seqErr = 1'b1;
          end
          nxt = ST_IDLE;
        end
        ST_SUSP: begin
          if (modeCmd) begin
            stb.selStatus = (cmdCode == CMD_RD_STATUS);
            stb.selArray  = (cmdCode == CMD_RD_ARRAY);
            stb.clrStatus = (cmdCode == CMD_CLR_STATUS);
          end else if (cmdCode == CMD_CONFIRM) begin
            stb.issue   = 1'b1;
            stb.kind    = OP_RESUME;
            stb.suspClr = 1'b1;
            nxt = ST_IDLE;
          end else begin
            stb.seqErr = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  // R9: a write ends in at most one of request, sequence error, lock error
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({stb.issue, stb.seqErr, stb.lockErr}) <= 1);

  // R5: while suspended the only request that may leave is a resume
  assert_suspend_only_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP && stb.issue) |-> (stb.kind == OP_RESUME));

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter  int ADDR_W     = 20,
  parameter  int DATA_W     = 16,
  parameter  int NUM_BLOCKS = 8,
  parameter  int BUF_DEPTH  = 8,
  localparam int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int IDX_W      = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              byteMode,
  input  logic              wpHigh,
  input  logic              engBusy,
  input  ctrl_stb_t         stb,
  input  logic [IDX_W-1:0]  bufRdIdx,
  output logic              wrEvt,
  output logic [7:0]        cmdCode,
  output logic              lockOk,
  output logic              anyLocked,
  output logic              countOk,
  output logic              lastData,
  output logic              opStart,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [IDX_W-1:0]  opCount,
  output logic [ADDR_W-1:0] bufRdAddr,
  output logic [DATA_W-1:0] bufRdData,
  output logic [7:0]        statusReg,
  output logic              readStatus
);

  logic                  wrQ;
  logic [BLK_W-1:0]      curBlk;
  logic [NUM_BLOCKS-1:0] lockBits;
  logic [DATA_W-1:0]     wData;
  logic [IDX_W-1:0]      bufN, bufIdx;
  logic [ADDR_W-1:0]     tgtAddr;
  logic [ADDR_W-1:0]     bufAddrMem [BUF_DEPTH];
  logic [DATA_W-1:0]     bufDataMem [BUF_DEPTH];
  logic                  seqErrQ, lockErrQ, suspQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrQ <= 1'b0;
    else        wrQ <= wrStrobe;
  end

  assign wrEvt     = wrStrobe & ~wrQ;
  assign cmdCode   = wrData[7:0];
  assign curBlk    = wrAddr[ADDR_W-1 -: BLK_W];
  assign lockOk    = lockBits[curBlk] | wpHigh;
  assign anyLocked = ~&lockBits;
  assign wData     = byteMode ? {{(DATA_W-8){1'b0}}, wrData[7:0]} : wrData;
  assign countOk   = wrData < DATA_W'(BUF_DEPTH);
  assign lastData  = (bufIdx == bufN);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     lockBits[b] <= 1'b1;
      else if (stb.clrLocks)                          lockBits[b] <= 1'b1;
      else if (stb.setLock && curBlk == BLK_W'(b))    lockBits[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufN    <= '0;
      bufIdx  <= '0;
      tgtAddr <= '0;
    end else begin
      if (stb.latchTarget) tgtAddr <= wrAddr;
      if (stb.bufStart) begin
        bufN   <= wrData[IDX_W-1:0];
        bufIdx <= '0;
      end else if (stb.bufPush) begin
        bufIdx <= bufIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufPush) begin
      bufAddrMem[bufIdx] <= wrAddr;
      bufDataMem[bufIdx] <= wData;
    end
  end

  assign bufRdAddr = bufAddrMem[bufRdIdx];
  assign bufRdData = bufDataMem[bufRdIdx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opStart <= 1'b0;
      opKind  <= 3'd0;
      opAddr  <= '0;
      opData  <= '0;
      opCount <= '0;
    end else begin
      opStart <= stb.issue;
      if (stb.issue) begin
        opKind  <= stb.kind;
        opAddr  <= (stb.kind == OP_BUFWR) ? tgtAddr : wrAddr;
        opData  <= wData;
        opCount <= bufN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqErrQ    <= 1'b0;
      lockErrQ   <= 1'b0;
      suspQ      <= 1'b0;
      readStatus <= 1'b0;
    end else begin
      if (stb.clrStatus) begin
        seqErrQ  <= 1'b0;
        lockErrQ <= 1'b0;
      end else begin
        if (stb.seqErr)  seqErrQ  <= 1'b1;
        if (stb.lockErr) lockErrQ <= 1'b1;
      end
      if (stb.suspSet)      suspQ <= 1'b1;
      else if (stb.suspClr) suspQ <= 1'b0;
      if (stb.selStatus)     readStatus <= 1'b1;
      else if (stb.selArray) readStatus <= 1'b0;
    end
  end

  assign statusReg = {~engBusy, suspQ, seqErrQ, lockErrQ, 4'b0000};

  // R12: every request follows a sampled strobe rise by one cycle
  assert_op_after_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
    opStart |-> $past(wrEvt));

  // R4: confirm-gated requests only follow a D0h write
  assert_confirm_gates_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opStart && (opKind == OP_BUFWR || opKind == OP_BLKERS || opKind == OP_CHIPERS))
      |-> ($past(cmdCode) == CMD_CONFIRM));

  // R6: a program request never targets a protected block
  assert_prog_lock_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opStart && opKind == OP_PROG) |-> $past(lockOk));

  // R7: a block can become locked only while write-protect was high
  assert_lock_needs_wp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(lockBits) & ~lockBits)) |-> $past(wpHigh));

  // R10: error flags hold until a clear-status write
  assert_sticky_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seqErrQ) && !$past(stb.clrStatus)) |-> seqErrQ);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter  int ADDR_W     = 20,
  parameter  int DATA_W     = 16,
  parameter  int NUM_BLOCKS = 8,
  parameter  int BUF_DEPTH  = 8,
  localparam int IDX_W      = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              byteMode,
  input  logic              wpHigh,
  input  logic              engBusy,
  input  logic [IDX_W-1:0]  bufRdIdx,
  output logic              opStart,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [IDX_W-1:0]  opCount,
  output logic [ADDR_W-1:0] bufRdAddr,
  output logic [DATA_W-1:0] bufRdData,
  output logic [7:0]        statusReg,
  output logic              readStatus
);

  ctrl_stb_t  stb;
  logic       wrEvt, lockOk, anyLocked, countOk, lastData;
  logic [7:0] cmdCode;

  flash_cmd_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEvt     (wrEvt),
    .cmdCode   (cmdCode),
    .engBusy   (engBusy),
    .wpHigh    (wpHigh),
    .lockOk    (lockOk),
    .anyLocked (anyLocked),
    .countOk   (countOk),
    .lastData  (lastData),
    .stb       (stb)
  );

  flash_cmd_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_BLOCKS (NUM_BLOCKS),
    .BUF_DEPTH  (BUF_DEPTH)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrStrobe   (wrStrobe),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .byteMode   (byteMode),
    .wpHigh     (wpHigh),
    .engBusy    (engBusy),
    .stb        (stb),
    .bufRdIdx   (bufRdIdx),
    .wrEvt      (wrEvt),
    .cmdCode    (cmdCode),
    .lockOk     (lockOk),
    .anyLocked  (anyLocked),
    .countOk    (countOk),
    .lastData   (lastData),
    .opStart    (opStart),
    .opKind     (opKind),
    .opAddr     (opAddr),
    .opData     (opData),
    .opCount    (opCount),
    .bufRdAddr  (bufRdAddr),
    .bufRdData  (bufRdData),
    .statusReg  (statusReg),
    .readStatus (readStatus)
  );

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        byteMode = 1'b0;
  logic        wpHigh = 1'b0;
  logic        engBusy = 1'b0;
  logic [2:0]  bufRdIdx = '0;
  logic        opStart;
  logic [2:0]  opKind;
  logic [19:0] opAddr;
  logic [15:0] opData;
  logic [2:0]  opCount;
  logic [19:0] bufRdAddr;
  logic [15:0] bufRdData;
  logic [7:0]  statusReg;
  logic        readStatus;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic        sStart;
  logic [2:0]  sKind;
  logic [19:0] sAddr;
  logic [15:0] sData;
  logic [2:0]  sCount;
  logic [7:0]  sStatus;

  always #10 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .byteMode(byteMode), .wpHigh(wpHigh), .engBusy(engBusy), .bufRdIdx(bufRdIdx),
    .opStart(opStart), .opKind(opKind), .opAddr(opAddr), .opData(opData),
    .opCount(opCount), .bufRdAddr(bufRdAddr), .bufRdData(bufRdData),
    .statusReg(statusReg), .readStatus(readStatus)
  );

  // vector: {req, addr, data, wp, expStart, expKind, expStatus}
  localparam int NV = 45;
  localparam logic [52:0] VEC [NV] = '{
    {4'd1,  20'h00100, 16'h0040, 1'b0, 1'b0, 3'd0, 8'h80}, // R1 setup
    {4'd1,  20'h00100, 16'hAB12, 1'b0, 1'b1, 3'd1, 8'h80}, // R1 program
    {4'd8,  20'h00200, 16'hFF10, 1'b0, 1'b0, 3'd0, 8'h80}, // R8 upper byte ignored
    {4'd1,  20'h00200, 16'h5555, 1'b0, 1'b1, 3'd1, 8'h80}, // R1 via 10h
    {4'd4,  20'h20000, 16'h0020, 1'b0, 1'b0, 3'd0, 8'h80}, // R4
    {4'd4,  20'h20000, 16'h00D0, 1'b0, 1'b1, 3'd3, 8'h80}, // R4 block erase
    {4'd4,  20'h00000, 16'h0030, 1'b0, 1'b0, 3'd0, 8'h80}, // R4
    {4'd4,  20'h00000, 16'h00D0, 1'b0, 1'b1, 3'd4, 8'h80}, // R4 chip erase
    {4'd9,  20'h00000, 16'h0077, 1'b0, 1'b0, 3'd0, 8'hA0}, // R9 reserved
    {4'd10, 20'h00000, 16'h0050, 1'b0, 1'b0, 3'd0, 8'h80}, // R10 clear
    {4'd7,  20'h40000, 16'h0060, 1'b0, 1'b0, 3'd0, 8'h80}, // R7
    {4'd7,  20'h40000, 16'h0001, 1'b0, 1'b0, 3'd0, 8'h90}, // R7 set refused
    {4'd10, 20'h00000, 16'h0050, 1'b0, 1'b0, 3'd0, 8'h80}, // R10
    {4'd7,  20'h40000, 16'h0060, 1'b1, 1'b0, 3'd0, 8'h80}, // R7
    {4'd7,  20'h40000, 16'h0001, 1'b1, 1'b0, 3'd0, 8'h80}, // R7 lock block 2
    {4'd6,  20'h40000, 16'h0040, 1'b0, 1'b0, 3'd0, 8'h80}, // R6
    {4'd6,  20'h40010, 16'h9999, 1'b0, 1'b0, 3'd0, 8'h90}, // R6 refused
    {4'd10, 20'h00000, 16'h0050, 1'b0, 1'b0, 3'd0, 8'h80}, // R10
    {4'd6,  20'h40000, 16'h0040, 1'b1, 1'b0, 3'd0, 8'h80}, // R6
    {4'd6,  20'h40010, 16'h1111, 1'b1, 1'b1, 3'd1, 8'h80}, // R6 wp overrides
    {4'd6,  20'h00000, 16'h0030, 1'b0, 1'b0, 3'd0, 8'h80}, // R6
    {4'd6,  20'h00000, 16'h00D0, 1'b0, 1'b0, 3'd0, 8'h90}, // R6 chip refused
    {4'd10, 20'h00000, 16'h0050, 1'b0, 1'b0, 3'd0, 8'h80}, // R10
    {4'd4,  20'h20000, 16'h0020, 1'b0, 1'b0, 3'd0, 8'h80}, // R4
    {4'd4,  20'h20000, 16'h00FF, 1'b0, 1'b0, 3'd0, 8'hA0}, // R4 no confirm
    {4'd10, 20'h00000, 16'h0050, 1'b0, 1'b0, 3'd0, 8'h80}, // R10
    {4'd7,  20'h40000, 16'h0060, 1'b1, 1'b0, 3'd0, 8'h80}, // R7
    {4'd7,  20'h40000, 16'h00D0, 1'b1, 1'b0, 3'd0, 8'h80}, // R7 clear all
    {4'd7,  20'h40000, 16'h0040, 1'b0, 1'b0, 3'd0, 8'h80}, // R7
    {4'd7,  20'h40010, 16'h2222, 1'b0, 1'b1, 3'd1, 8'h80}, // R7 now unlocked
    {4'd2,  20'h00300, 16'h00E8, 1'b0, 1'b0, 3'd0, 8'h80}, // R2
    {4'd2,  20'h00300, 16'h0001, 1'b0, 1'b0, 3'd0, 8'h80}, // R2 N=1
    {4'd2,  20'h00300, 16'hAAAA, 1'b0, 1'b0, 3'd0, 8'h80}, // R2
    {4'd2,  20'h00302, 16'hBBBB, 1'b0, 1'b0, 3'd0, 8'h80}, // R2
    {4'd2,  20'h00300, 16'h00D0, 1'b0, 1'b1, 3'd2, 8'h80}, // R2 confirm
    {4'd3,  20'h00300, 16'h00E8, 1'b0, 1'b0, 3'd0, 8'h80}, // R3
    {4'd3,  20'h00300, 16'h0000, 1'b0, 1'b0, 3'd0, 8'h80}, // R3 N=0
    {4'd3,  20'h00300, 16'hCCCC, 1'b0, 1'b0, 3'd0, 8'h80}, // R3
    {4'd3,  20'h00300, 16'h00FF, 1'b0, 1'b0, 3'd0, 8'hA0}, // R3 abort
    {4'd10, 20'h00000, 16'h0050, 1'b0, 1'b0, 3'd0, 8'h80}, // R10
    {4'd2,  20'h00300, 16'h00E8, 1'b0, 1'b0, 3'd0, 8'h80}, // R2
    {4'd2,  20'h00300, 16'h0008, 1'b0, 1'b0, 3'd0, 8'hA0}, // R2 count too big
    {4'd10, 20'h00000, 16'h0050, 1'b0, 1'b0, 3'd0, 8'h80}, // R10
    {4'd9,  20'h00000, 16'h00D0, 1'b0, 1'b0, 3'd0, 8'hA0}, // R9 stray confirm
    {4'd10, 20'h00000, 16'h0050, 1'b0, 1'b0, 3'd0, 8'h80}  // R10
  };

  task automatic doWrite(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wrAddr = a;
    wrData = d;
    wrStrobe = 1'b1;
    @(negedge clk);
    sStart = opStart;
    sKind = opKind;
    sAddr = opAddr;
    sData = opData;
    sCount = opCount;
    sStatus = statusReg;
    wrStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "reset status", {24'h0, statusReg}, 32'h80);
    check("R11", "reset readStatus", {31'h0, readStatus}, 32'h0);
    check("R11", "reset opStart", {31'h0, opStart}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wpHigh = VEC[i][12];
      doWrite(VEC[i][48:29], VEC[i][28:13]);
      nChecks++;
      if (sStart !== VEC[i][11] || (VEC[i][11] && sKind !== VEC[i][10:8]) ||
          sStatus !== VEC[i][7:0]) begin
        nFail++;
        $display("FAIL R%0d vector %0d: actual %b/%0d/%h expected %b/%0d/%h",
                 VEC[i][52:49], i, sStart, sKind, sStatus,
                 VEC[i][11], VEC[i][10:8], VEC[i][7:0]);
      end
    end
    wpHigh = 1'b0;

    // R12 held strobe counts once
    @(negedge clk);
    wrAddr = 20'h00500; wrData = 16'h0040; wrStrobe = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R12", "held strobe opStart", {31'h0, opStart}, 32'h0);
    end
    wrStrobe = 1'b0;
    @(negedge clk);
    doWrite(20'h00500, 16'h3456);
    check("R12", "program after held strobe", {sStart, sKind, sData}, {1'b1, 3'd1, 16'h3456});
    check("R1", "program address", {12'h0, sAddr}, 32'h00500);

    // R1 byte mode masks upper data byte
    byteMode = 1'b1;
    doWrite(20'h00600, 16'h0040);
    doWrite(20'h00600, 16'hABCD);
    check("R1", "byte mode data", {15'h0, sStart, sData}, {15'h0, 1'b1, 16'h00CD});
    byteMode = 1'b0;

    // R2 buffered write fields and readout
    doWrite(20'h00400, 16'h00E8);
    doWrite(20'h00400, 16'h0001);
    doWrite(20'h00400, 16'h1111);
    doWrite(20'h00402, 16'h2222);
    doWrite(20'h00400, 16'h00D0);
    check("R2", "buffered request", {sStart, sKind, sCount, sAddr}, {1'b1, 3'd2, 3'd1, 20'h00400});
    bufRdIdx = 3'd1; #1;
    check("R2", "buffer index 1", {bufRdAddr, bufRdData[11:0]}, {20'h00402, 12'h222});
    bufRdIdx = 3'd0; #1;
    check("R2", "buffer index 0 data", {16'h0, bufRdData}, 32'h1111);

    // R11 read mode selection
    doWrite(20'h0, 16'h0070);
    check("R11", "readStatus after 70h", {31'h0, readStatus}, 32'h1);
    doWrite(20'h0, 16'h00FF);
    check("R11", "readStatus after FFh", {31'h0, readStatus}, 32'h0);

    // R9 suspend with engine idle is ignored
    doWrite(20'h0, 16'h00B0);
    check("R9", "idle suspend", {23'h0, sStart, sStatus}, {23'h0, 1'b0, 8'h80});

    // R6 suspend aimed at locked block
    wpHigh = 1'b1;
    doWrite(20'h60000, 16'h0060);
    doWrite(20'h60000, 16'h0001);
    wpHigh = 1'b0;
    engBusy = 1'b1;
    doWrite(20'h60000, 16'h00B0);
    check("R6", "locked suspend", {23'h0, sStart, sStatus}, {23'h0, 1'b0, 8'h10});
    doWrite(20'h0, 16'h0050);
    check("R10", "clear while busy", {24'h0, sStatus}, 32'h00);

    // R5 suspend / resume
    doWrite(20'h00000, 16'h00B0);
    check("R5", "suspend request", {20'h0, sStart, sKind, sStatus}, {20'h0, 1'b1, 3'd5, 8'h40});
    engBusy = 1'b0;
    #1;
    check("R10", "ready follows busy", {24'h0, statusReg}, 32'hC0);
    doWrite(20'h0, 16'h0040);
    check("R5", "command while suspended", {23'h0, sStart, sStatus}, {23'h0, 1'b0, 8'hE0});
    doWrite(20'h0, 16'h0050);
    check("R5", "still suspended", {24'h0, sStatus}, 32'hC0);
    doWrite(20'h0, 16'h00D0);
    check("R5", "resume request", {20'h0, sStart, sKind, sStatus}, {20'h0, 1'b1, 3'd6, 8'h80});

    // R13 command while engine busy
    engBusy = 1'b1;
    doWrite(20'h20000, 16'h0020);
    check("R13", "busy erase setup", {23'h0, sStart, sStatus}, {23'h0, 1'b0, 8'h20});
    engBusy = 1'b0;
    doWrite(20'h0, 16'h0050);
    check("R13", "back to idle", {24'h0, sStatus}, 32'h80);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule